// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block feeds a hash core with message bytes fetched from memory. A control front end supplies a start pulse, a source address, an expected total byte count and two mode bits. In descriptor mode the source address points at a list of 8-byte descriptors. Each descriptor names one memory segment. The walker reads the descriptors one after another and sends the bytes of every segment, in list order, as one unbroken byte stream. In plain mode the source address is the start of one contiguous buffer, and the walker streams the programmed number of bytes from it.

The walker reads memory through a byte-wide request/response port and allows one request in flight at a time. Its stream output uses valid/ready and marks the final byte of the message with a last flag. A companion flag raised with that last byte tells the hash core whether to add its own padding. In accumulate mode the caller has already put the padding into the data, so the walker leaves that flag low. When a walk ends, the walker raises a one-cycle done pulse. An error indication comes with that pulse if the descriptor list and the programmed total do not agree.

Top module: `sg_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `mem_req_valid` and `out_valid` are all 0.
- R2: In plain mode (`sg_en`=0) the walker streams `total_len` bytes read from consecutive addresses starting at `src_addr`. It sets `out_last` on the final byte, and its done pulse follows with `err`=0.
- R3: In descriptor mode the walker reads each descriptor as 8 bytes at the list pointer. Bytes 0..3 form a little-endian length word: bit 31 is the end flag and bits 30:0 are the segment byte count. Bytes 4..7 form a little-endian segment address. The next descriptor starts 8 bytes after the previous one.
- R4: The bytes of all segments leave the walker in list order, with no gap and no filler, and `out_last` is set only on the final byte of the message.
- R5: A descriptor with a byte count of 0 produces no output byte, and the walk continues with the next descriptor.
- R6: The walk stops after the segment of the first flagged descriptor. No descriptor after it is read or streamed.
- R7: If the running byte count reaches `total_len` before the end of a flagged segment, the walker sets `out_last` on that byte, stops, and raises `err` with `done`.
- R8: If the flagged segment ends before `total_len` bytes have been sent, `out_last` is set on its final byte and `err` is raised with `done`.
- R9: `out_pad` is 1 on the last byte when `accum_en`=0. It is 0 on every byte when `accum_en`=1, and caller-padded data passes through unchanged.
- R10: A plain-mode start with `total_len`=0 yields a done pulse with `err`=0 and no output byte.
- R11: A start pulse that arrives while `busy` is 1 is ignored. It causes no extra byte and no extra done pulse.
- R12: While `out_valid`=1 and `out_ready`=0, the output byte and its flags hold steady until they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| sg_en | input | 1 | 1 = descriptor list, 0 = contiguous buffer |
| accum_en | input | 1 | 1 = data already padded by caller |
| src_addr | input | ADDR_W | List base or buffer start |
| total_len | input | CNT_W | Expected message byte count |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | List/total mismatch, valid with done |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Byte address to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Hash core accepts byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of message |
| out_pad | output | 1 | Hash core should append padding |

## Verification
The bench builds the walker with ADDR_W=32 and CNT_W=16. The 16-bit counter keeps the total-versus-sent comparisons small, and the full-width address still carries the 32-bit segment address from each descriptor. Only the low 12 address bits are decoded by the bench memory, so descriptor lists, segment data and a decoy descriptor placed after the flagged one all fit in a 4 KiB model. An LFSR throttles both memory acceptance and stream readiness, which exercises the hold behaviour and the single-request flow under stalls.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;

    localparam int DESC_BYTES = 8;
    localparam int SEG_W      = 31;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DESC_REQ,
        W_DESC_WAIT,
        W_DATA_REQ,
        W_DATA_WAIT,
        W_DATA_OUT,
        W_FINISH
    } walk_state_e;

    // 64-bit descriptor image, byte 0 in the least significant position
    typedef struct packed {
        logic [31:0]      seg_addr;
        logic             end_flag;
        logic [SEG_W-1:0] seg_len;
    } desc_t;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic       pad;
    } beat_t;

    function automatic desc_t to_desc(input logic [8*DESC_BYTES-1:0] raw);
        return desc_t'(raw);
    endfunction

endpackage

// File: rtl/sg_desc_collect.sv
module sg_desc_collect
    import sg_walker_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       complete,
    output desc_t      desc_next
);
    localparam int IW = $clog2(DESC_BYTES);

    logic [IW-1:0]           idx;
    logic [8*DESC_BYTES-1:0] shreg;
    logic [8*DESC_BYTES-1:0] merged;

    always_comb begin
        merged = shreg;
        merged[8*idx +: 8] = byte_in;
        complete  = byte_vld && (idx == IW'(DESC_BYTES - 1));
        desc_next = to_desc(merged);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx   <= '0;
            shreg <= '0;
        end else if (byte_vld) begin
            shreg <= merged;
            idx   <= complete ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/sg_byte_stage.sv
module sg_byte_stage
    import sg_walker_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t beat_in,
    input  logic  ready,
    output logic  valid,
    output beat_t beat_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            beat_out <= '0;
        end else if (load) begin
            valid    <= 1'b1;
            beat_out <= beat_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(beat_out))) // R12
        else $error("held beat changed");

    AST_PAD_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
        (valid && beat_out.pad) |-> beat_out.last) // R9
        else $error("pad without last");

endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sg_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sg_en,
    input  logic              accum_en,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [CNT_W-1:0]  total_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              out_pad
);
    walk_state_e       state;
    logic [ADDR_W-1:0] list_ptr, cur_addr;
    logic [SEG_W-1:0]  seg_rem;
    logic              seg_flag;
    logic [CNT_W-1:0]  sent, total;
    logic              accum_q, sg_q, err_q, last_q;

    logic  req_fire, out_fire, hit_total, seg_end, byte_last, byte_err;
    logic  desc_done;
    desc_t desc_now;
    beat_t beat_in, beat_out;

    // request side: one read in flight
    always_comb begin
        mem_req_valid = (state == W_DESC_REQ) || ((state == W_DATA_REQ) && (sent != total));
        mem_req_addr  = (state == W_DESC_REQ) ? list_ptr : cur_addr;
        req_fire      = mem_req_valid && mem_req_ready;
    end

    // end-of-message decision for the byte being returned
    always_comb begin
        hit_total = (CNT_W'(sent + 1'b1) == total);
        seg_end   = sg_q && seg_flag && (seg_rem == SEG_W'(1));
        byte_last = hit_total || seg_end;
        byte_err  = sg_q && byte_last && !(hit_total && seg_end);
        beat_in   = '{data: mem_rsp_data, last: byte_last, pad: byte_last && !accum_q};
    end

    sg_desc_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .clr      (state == W_IDLE),
        .byte_vld (state == W_DESC_WAIT && mem_rsp_valid),
        .byte_in  (mem_rsp_data),
        .complete (desc_done),
        .desc_next(desc_now)
    );

    sg_byte_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (state == W_DATA_WAIT && mem_rsp_valid),
        .beat_in (beat_in),
        .ready   (out_ready),
        .valid   (out_valid),
        .beat_out(beat_out)
    );

    assign out_data = beat_out.data;
    assign out_last = beat_out.last;
    assign out_pad  = beat_out.pad;
    assign out_fire = out_valid && out_ready;
    assign busy     = (state != W_IDLE);
    assign done     = (state == W_FINISH);
    assign err      = done && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            list_ptr <= '0;
            cur_addr <= '0;
            seg_rem  <= '0;
            seg_flag <= 1'b0;
            sent     <= '0;
            total    <= '0;
            accum_q  <= 1'b0;
            sg_q     <= 1'b0;
            err_q    <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            unique case (state)
                W_IDLE: if (start) begin
                    total   <= total_len;
                    accum_q <= accum_en;
                    sg_q    <= sg_en;
                    sent    <= '0;
                    err_q   <= 1'b0;
                    if (sg_en) begin
                        list_ptr <= src_addr;
                        state    <= W_DESC_REQ;
                    end else begin
                        cur_addr <= src_addr;
                        state    <= (total_len == '0) ? W_FINISH : W_DATA_REQ;
                    end
                end
                W_DESC_REQ: if (req_fire) begin
                    list_ptr <= list_ptr + 1'b1;
                    state    <= W_DESC_WAIT;
                end
                W_DESC_WAIT: if (mem_rsp_valid) begin
                    if (!desc_done) begin
                        state <= W_DESC_REQ;
                    end else begin
                        seg_rem  <= desc_now.seg_len;
                        seg_flag <= desc_now.end_flag;
                        cur_addr <= ADDR_W'(desc_now.seg_addr);
                        if (desc_now.seg_len != '0) begin
                            state <= W_DATA_REQ;
                        end else if (desc_now.end_flag) begin
                            err_q <= (sent != total);
                            state <= W_FINISH;
                        end else begin
                            state <= W_DESC_REQ;
                        end
                    end
                end
                W_DATA_REQ: begin
                    if (sent == total) begin
                        err_q <= 1'b1;
                        state <= W_FINISH;
                    end else if (req_fire) begin
                        cur_addr <= cur_addr + 1'b1;
                        state    <= W_DATA_WAIT;
                    end
                end
                W_DATA_WAIT: if (mem_rsp_valid) begin
                    err_q  <= byte_err;
                    last_q <= byte_last;
                    state  <= W_DATA_OUT;
                end
                W_DATA_OUT: if (out_fire) begin
                    sent    <= sent + 1'b1;
                    seg_rem <= seg_rem - 1'b1;
                    if (last_q)                              state <= W_FINISH;
                    else if (sg_q && seg_rem == SEG_W'(1))   state <= W_DESC_REQ;
                    else                                     state <= W_DATA_REQ;
                end
                W_FINISH: state <= W_IDLE;
                default:  state <= W_IDLE;
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !out_valid)) // R1
        else $error("activity while idle");

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> done) // R4
        else $error("no done after last byte");

    AST_SENT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sent <= total)) // R7
        else $error("sent beyond total");

    AST_NO_REQ_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mem_req_valid) // R12
        else $error("request while byte held");

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)) // R11
        else $error("done not a single pulse");

endmodule

// File: tb/sg_walker_bench.sv
module sg_walker_bench;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start, sg_en, accum_en;
    logic [AW-1:0] src_addr;
    logic [CW-1:0] total_len;
    logic          busy, done, err;
    logic          mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [7:0]    mem_rsp_data;
    logic          out_valid, out_ready, out_last, out_pad;
    logic [7:0]    out_data;

    always #5 clk = ~clk;

    sg_walker #(.ADDR_W(AW), .CNT_W(CW)) u_sg_walker (
        .clk(clk), .rst(rst), .start(start), .sg_en(sg_en), .accum_en(accum_en),
        .src_addr(src_addr), .total_len(total_len), .busy(busy), .done(done), .err(err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_pad(out_pad)
    );

    logic [7:0]  mem [0:4095];
    logic [9:0]  exp_q [$];
    logic [15:0] lfsr;
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    logic        last_err = 1'b0;
    string       cur_tag = "R2";
    logic        held_prev = 1'b0;
    logic [9:0]  held_val = '0;

    // memory model and throttling
    always @(posedge clk) begin
        if (rst) begin
            lfsr          <= 16'hACE1;
            mem_req_ready <= 1'b0;
            out_ready     <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready <= lfsr[0] | lfsr[3];
            out_ready     <= lfsr[5] | lfsr[8];
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= mem[mem_req_addr[11:0]];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (held_prev) begin
                checks++;
                if (!out_valid || {out_data, out_last, out_pad} != held_val) begin
                    errors++;
                    $display("FAIL R12 held beat changed: got %h/%0b expected %h/1",
                             {out_data, out_last, out_pad}, out_valid, held_val);
                end
            end
            held_prev = out_valid && !out_ready;
            held_val  = {out_data, out_last, out_pad};
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s unexpected byte: got %h expected none", cur_tag,
                             {out_data, out_last, out_pad});
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    if ({out_data, out_last, out_pad} != e) begin
                        errors++;
                        $display("FAIL %s byte/last/pad: got %h expected %h", cur_tag,
                                 {out_data, out_last, out_pad}, e);
                    end
                end
            end
            if (done) begin
                done_cnt++;
                last_err = err;
            end
        end
    end

    task automatic check(input string tag, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, want);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) mem[(a + i) & 4095] = w[8*i +: 8];
    endtask

    // R3: length word first (bit 31 end flag), address word second, little endian
    task automatic put_desc(input int a, input int len, input logic flag, input int sa);
        put_word(a, {flag, 31'(len)});
        put_word(a + 4, 32'(sa));
    endtask

    task automatic fill(input int a, input int n, input int seed);
        for (int i = 0; i < n; i++) mem[(a + i) & 4095] = 8'(seed + i * 29);
    endtask

    task automatic expect_span(input int a, input int n, input logic last_end, input logic pad);
        for (int i = 0; i < n; i++) begin
            logic l;
            l = last_end && (i == n - 1);
            exp_q.push_back({mem[(a + i) & 4095], l, l && pad});
        end
    endtask

    task automatic padded_block(input int a, input int n);
        for (int i = 0; i < n; i++) mem[(a + i) & 4095] = 8'h00;
        mem[a & 4095] = 8'h61; mem[(a + 1) & 4095] = 8'h62; mem[(a + 2) & 4095] = 8'h63;
        mem[(a + 3) & 4095] = 8'h80; mem[(a + n - 1) & 4095] = 8'h18;
    endtask

    task automatic run(input string tag, input logic sg, input logic acc, input int src,
                       input int tot, input logic exp_err, input logic poke);
        int old;
        old = done_cnt;
        cur_tag = tag;
        @(negedge clk);
        start = 1'b1; sg_en = sg; accum_en = acc; src_addr = AW'(src); total_len = CW'(tot);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            check("R11 busy before poke", int'(busy), 1);
            start = 1'b1; sg_en = 1'b0; src_addr = 32'h100; total_len = 16'd9;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 5000 && done_cnt == old; k++) @(negedge clk);
        check({tag, " done seen"}, done_cnt, old + 1);
        repeat (6) @(negedge clk);
        check({tag, " R11 single done"}, done_cnt, old + 1);
        check({tag, " idle after"}, int'(busy), 0);
        check({tag, " all bytes"}, exp_q.size(), 0);
        check({tag, " err"}, int'(last_err), int'(exp_err));
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        rst = 1'b1; start = 1'b0; sg_en = 1'b0; accum_en = 1'b0; src_addr = '0; total_len = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 reset quiet", int'({busy, done, mem_req_valid, out_valid}), 0);
        rst = 1'b0;

        // R2 plain buffer with auto padding
        fill(32'h100, 5, 8'h11);
        expect_span(32'h100, 5, 1'b1, 1'b1);
        run("R2", 1'b0, 1'b0, 32'h100, 5, 1'b0, 1'b0);

        // R9 plain accumulate: pre-padded block, no pad request
        padded_block(32'h180, 64);
        expect_span(32'h180, 64, 1'b1, 1'b0);
        run("R9", 1'b0, 1'b1, 32'h180, 64, 1'b0, 1'b0);

        // R10 zero-length plain
        run("R10", 1'b0, 1'b0, 32'h100, 0, 1'b0, 1'b0);

        // R3 R4 R6 three segments 6,3,3 plus a decoy after the flagged one; R11 poke
        put_desc(32'h200, 6, 1'b0, 32'h300);
        put_desc(32'h208, 3, 1'b0, 32'h340);
        put_desc(32'h210, 3, 1'b1, 32'h380);
        put_desc(32'h218, 5, 1'b1, 32'h3c0);
        fill(32'h300, 6, 8'h61); fill(32'h340, 3, 8'h67); fill(32'h380, 3, 8'h6a);
        fill(32'h3c0, 5, 8'hee);
        expect_span(32'h300, 6, 1'b0, 1'b1);
        expect_span(32'h340, 3, 1'b0, 1'b1);
        expect_span(32'h380, 3, 1'b1, 1'b1);
        run("R4", 1'b1, 1'b0, 32'h200, 12, 1'b0, 1'b1);

        // R5 zero-length segment in the middle
        put_desc(32'h400, 2, 1'b0, 32'h500);
        put_desc(32'h408, 0, 1'b0, 32'h600);
        put_desc(32'h410, 3, 1'b1, 32'h520);
        fill(32'h500, 2, 8'h31); fill(32'h600, 4, 8'hdd); fill(32'h520, 3, 8'h41);
        expect_span(32'h500, 2, 1'b0, 1'b1);
        expect_span(32'h520, 3, 1'b1, 1'b1);
        run("R5", 1'b1, 1'b0, 32'h400, 5, 1'b0, 1'b0);

        // R7 total reached inside the flagged segment
        put_desc(32'h700, 4, 1'b0, 32'h800);
        put_desc(32'h708, 4, 1'b1, 32'h840);
        fill(32'h800, 4, 8'h90); fill(32'h840, 4, 8'ha0);
        expect_span(32'h800, 4, 1'b0, 1'b1);
        expect_span(32'h840, 2, 1'b1, 1'b1);
        run("R7", 1'b1, 1'b0, 32'h700, 6, 1'b1, 1'b0);

        // R8 flagged segment ends short of total
        put_desc(32'h900, 3, 1'b1, 32'ha00);
        fill(32'ha00, 3, 8'h51);
        expect_span(32'ha00, 3, 1'b1, 1'b1);
        run("R8", 1'b1, 1'b0, 32'h900, 10, 1'b1, 1'b0);

        // R9 descriptor accumulate
        put_desc(32'hb00, 64, 1'b1, 32'hc00);
        padded_block(32'hc00, 64);
        expect_span(32'hc00, 64, 1'b1, 1'b0);
        run("R9", 1'b1, 1'b1, 32'hb00, 64, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule